// File: doc/BRIEF.md
# Multi-Channel Prescaled Pulse-Width Modulator

This block produces up to four independent pulse-width-modulated outputs. Each channel has its own configuration: a clock divider setting, a period length in counter steps, a high-time in counter steps, and an on/off control. Software programs these through a small memory-mapped read/write port. Reads are combinational and writes are single-cycle.

A running channel's step counter advances once every (divider+1) clocks and wraps after a programmed number of steps. The output is high for the first high-time steps of every period. Settings written while a channel runs are held back until the current period ends, so no period mixes old and new settings. Turning a channel off forces its output low at once. Turning it on restarts its counting from zero with the settings programmed at that moment.

Top module: `pwm_bank`

## Requirements
- R1: Channel c occupies the addresses with bus_addr[6:5]=c. Word offset 0x00 holds the divider in bits 7:0, 0x04 the period length in bits 7:0, 0x08 the high-time in bits 15:0, and 0x18 the run flag in bit 0. A read with bus_sel=1 and bus_wr=0 returns the stored value, with unused bits reading zero.
- R2: With divider P and period length M>0, the output repeats every (P+1)*M clocks. In each period it is high for (P+1)*D clocks, where D is the high-time, starting at the period start.
- R3: A high-time of 0 keeps the output low, and a high-time of at least M keeps it high for the whole period.
- R4: A period length of 0 holds the output low while the channel runs.
- R5: Divider, period and high-time values written to a running channel take effect only from the next period boundary. The period in progress completes with the old values.
- R6: Writing 0 to the run flag drives the output low in the cycle that follows the write edge, without finishing the period.
- R7: Writing 1 to a stopped channel's run flag leaves the output low for one cycle. It then starts a new period from count zero with the values programmed at that time.
- R8: Offsets other than the four above, addresses with bus_addr[1:0]≠0, and channel indices at or above NUM_CH read as zero, and writes to them change no register.
- R9: Channels run independently: programming one channel does not change another channel's output or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address: channel in 6:5, offset in 4:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
On every cycle, the assertions check the following. A stopped channel's output is low. The step counter stays below the active period length. The active settings stay frozen between period boundaries. An active high-time or period length of zero keeps the output low. A restart clears the counters. The exact period and high-time lengths, the deferral of a mid-period change to the next period, the register masking, and the handling of unmapped addresses are shown only by the bench scenarios, which count output samples and read registers back.

// File: rtl/pwm_bank_pkg.sv
// Shared constants and register selector encoding for the PWM bank.
package pwm_bank_pkg;
    localparam int DATA_W   = 32;
    localparam int CH_SHIFT = 5;               // channel window of 32 bytes
    localparam int MAX_CH   = 4;
    localparam int CH_IDX_W = $clog2(MAX_CH);
    localparam int ADDR_W   = CH_SHIFT + CH_IDX_W;

    // Word index inside a channel window (byte offset >> 2)
    typedef enum logic [2:0] {
        SEL_DIV  = 3'd0,
        SEL_PER  = 3'd1,
        SEL_HIGH = 3'd2,
        SEL_RUN  = 3'd6
    } reg_sel_e;
endpackage

// File: rtl/pwm_chan_regs.sv
// Programmed-value register file of one channel.
// Assumes wr_en is already qualified by channel match and word alignment.
// Unmapped selectors read zero and ignore writes.
module pwm_chan_regs
    import pwm_bank_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int PER_W  = 8,
    parameter int HIGH_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        word_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DIV_W-1:0]  prog_div,
    output logic [PER_W-1:0]  prog_per,
    output logic [HIGH_W-1:0] prog_high,
    output logic              run_en,
    output logic [DATA_W-1:0] rdata
);
    // Register update on a qualified write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_div  <= '0;
            prog_per  <= '0;
            prog_high <= '0;
            run_en    <= 1'b0;
        end else if (wr_en) begin
            case (word_sel)
                SEL_DIV:  prog_div  <= wdata[DIV_W-1:0];
                SEL_PER:  prog_per  <= wdata[PER_W-1:0];
                SEL_HIGH: prog_high <= wdata[HIGH_W-1:0];
                SEL_RUN:  run_en    <= wdata[0];
                default:  ;
            endcase
        end
    end

    // Read-back mux with zero-filled unused bits
    always_comb begin
        case (word_sel)
            SEL_DIV:  rdata = DATA_W'(prog_div);
            SEL_PER:  rdata = DATA_W'(prog_per);
            SEL_HIGH: rdata = DATA_W'(prog_high);
            SEL_RUN:  rdata = DATA_W'(run_en);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwm_chan_core.sv
// Counting engine of one channel: a divider, a step counter and active
// (shadow) settings that reload only at a period boundary or on restart.
// Assumes HIGH_W >= PER_W. The output is forced low whenever run_en is low.
module pwm_chan_core #(
    parameter int DIV_W  = 8,
    parameter int PER_W  = 8,
    parameter int HIGH_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [DIV_W-1:0]  prog_div,
    input  logic [PER_W-1:0]  prog_per,
    input  logic [HIGH_W-1:0] prog_high,
    output logic              pwm_out
);
    logic              running;
    logic [DIV_W-1:0]  act_div, div_cnt;
    logic [PER_W-1:0]  act_per, step_cnt;
    logic [HIGH_W-1:0] act_high;
    logic              per_zero, step_tick, wrap;

    assign per_zero  = (act_per == '0);
    assign step_tick = running && run_en && !per_zero && (div_cnt == act_div);
    assign wrap      = step_tick && (step_cnt == act_per - PER_W'(1));

    // Divider, step counter and active-setting reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            act_div  <= '0;
            act_per  <= '0;
            act_high <= '0;
            div_cnt  <= '0;
            step_cnt <= '0;
        end else begin
            running <= run_en;
            if (run_en && (!running || per_zero || wrap)) begin
                act_div  <= prog_div;
                act_per  <= prog_per;
                act_high <= prog_high;
                div_cnt  <= '0;
                step_cnt <= '0;
            end else if (step_tick) begin
                div_cnt  <= '0;
                step_cnt <= step_cnt + PER_W'(1);
            end else if (running && run_en) begin
                div_cnt  <= div_cnt + DIV_W'(1);
            end
        end
    end

    // Output high for the first act_high steps of each period
    assign pwm_out = run_en && running && !per_zero && (HIGH_W'(step_cnt) < act_high);

    // R2: the step counter never reaches the active period length
    a_r2_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !per_zero) |-> (step_cnt < act_per));
    // R5: active settings hold between period boundaries
    a_r5_settings_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_en && !per_zero && !wrap) |=>
        ($stable(act_div) && $stable(act_per) && $stable(act_high)));
    // R3: zero active high-time gives a low output
    a_r3_zero_high_low: assert property (@(posedge clk) disable iff (!rst_n)
        (running && act_high == '0) |-> !pwm_out);
    // R4: zero active period length gives a low output
    a_r4_zero_period_low: assert property (@(posedge clk) disable iff (!rst_n)
        per_zero |-> !pwm_out);
    // R7: a restart clears both counters
    a_r7_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !running) |=> (step_cnt == '0 && div_cnt == '0));
endmodule

// File: rtl/pwm_bank.sv
// Top of the PWM bank: address decode, per-channel register files and
// counting engines, and the read-data mux. NUM_CH must not exceed 4.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 8,
    parameter int PER_W  = 8,
    parameter int HIGH_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [CH_IDX_W-1:0] acc_ch;
    logic [2:0]          acc_word;
    logic                aligned;
    logic [DATA_W-1:0]   ch_rdata [MAX_CH];
    logic [NUM_CH-1:0]   ch_run;

    assign acc_ch   = bus_addr[ADDR_W-1:CH_SHIFT];
    assign acc_word = bus_addr[CH_SHIFT-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
        if (c < NUM_CH) begin : g_impl
            logic              wr_hit;
            logic [DIV_W-1:0]  p_div;
            logic [PER_W-1:0]  p_per;
            logic [HIGH_W-1:0] p_high;

            assign wr_hit = bus_sel && bus_wr && aligned && (acc_ch == CH_IDX_W'(c));

            pwm_chan_regs #(.DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)) u_regs (
                .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .word_sel(acc_word),
                .wdata(bus_wdata), .prog_div(p_div), .prog_per(p_per),
                .prog_high(p_high), .run_en(ch_run[c]), .rdata(ch_rdata[c]));

            pwm_chan_core #(.DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)) u_core (
                .clk(clk), .rst_n(rst_n), .run_en(ch_run[c]), .prog_div(p_div),
                .prog_per(p_per), .prog_high(p_high), .pwm_out(pwm_out[c]));

            // R6: a stopped channel drives its output low
            a_r6_off_is_low: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_run[c] |-> !pwm_out[c]);
        end else begin : g_absent
            assign ch_rdata[c] = '0;
        end
    end

    // Read mux: zero for writes, misaligned or absent-channel accesses
    always_comb begin
        if (bus_sel && !bus_wr && aligned && (int'(acc_ch) < NUM_CH))
            bus_rdata = ch_rdata[acc_ch];
        else
            bus_rdata = '0;
    end
endmodule

// File: tb/tb_pwm_bank.sv
// Directed bench: one task per scenario, each checks its own results.
module tb_pwm_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    int          n_chk = 0, n_fail = 0;

    localparam logic [4:0] O_DIV = 5'h00, O_PER = 5'h04, O_HIGH = 5'h08, O_RUN = 5'h18;

    pwm_bank dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out));

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input int ch, input logic [4:0] ofs, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {2'(ch), ofs}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input logic [4:0] ofs, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {2'(ch), ofs};
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic measure(input int ch, input int n, output int highs, output int rises);
        logic prev = pwm_out[ch];
        highs = 0; rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            highs += int'(pwm_out[ch]);
            if (pwm_out[ch] && !prev) rises++;
            prev = pwm_out[ch];
        end
    endtask

    task automatic setup(input int ch, input int dv, input int pr, input int hi);
        wr(ch, O_DIV, dv); wr(ch, O_PER, pr); wr(ch, O_HIGH, hi); wr(ch, O_RUN, 1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, O_PER, d);  chk("R1 reset period", d, 0);
        rd(3, O_RUN, d);  chk("R1 reset run", d, 0);
        chk("R6 reset outputs", 32'(pwm_out), 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(1, O_DIV, 32'hFFFF_FFFF);  rd(1, O_DIV, d);  chk("R1 divider mask", d, 32'hFF);
        wr(1, O_HIGH, 32'h0001_ABCD); rd(1, O_HIGH, d); chk("R1 high mask", d, 32'hABCD);
        wr(1, O_PER, 32'h0000_0134);  rd(1, O_PER, d);  chk("R1 period mask", d, 32'h34);
        wr(1, O_RUN, 32'hFFFF_FFFE);  rd(1, O_RUN, d);  chk("R1 run bit0", d, 0);
        chk("R9 ch1 idle output", 32'(pwm_out[1]), 0);
    endtask

    task automatic t_period();
        int h, r;
        setup(0, 1, 5, 2);
        setup(3, 0, 3, 1);
        measure(0, 40, h, r);
        chk("R2 high clocks in 4 periods", h, 16);
        chk("R2 period count", r, 4);
        measure(3, 30, h, r);
        chk("R9 ch3 high clocks", h, 10);
    endtask

    task automatic t_edges();
        int h, r;
        setup(1, 0, 4, 0);
        measure(1, 20, h, r); chk("R3 zero high", h, 0);
        wr(1, O_HIGH, 9);
        repeat (6) @(negedge clk);
        measure(1, 20, h, r); chk("R3 high above period", h, 20);
        setup(2, 0, 0, 3);
        measure(2, 20, h, r); chk("R4 zero period low", h, 0);
        wr(1, O_RUN, 0);
        wr(2, O_RUN, 0);
    endtask

    task automatic t_shadow();
        int h, r;
        logic prev;
        setup(2, 0, 8, 2);
        prev = pwm_out[2];
        do begin
            @(negedge clk);
            if (pwm_out[2] && !prev) break;
            prev = pwm_out[2];
        end while (1);
        wr(2, O_HIGH, 6);                      // now at step 1
        chk("R5 step1 old high", 32'(pwm_out[2]), 1);
        @(negedge clk);                        // step 2
        chk("R5 step2 still old", 32'(pwm_out[2]), 0);
        repeat (5) @(negedge clk);             // step 7
        measure(2, 8, h, r);
        chk("R5 new high next period", h, 6);
    endtask

    task automatic t_stop_restart();
        logic [31:0] d;
        int h, r;
        while (!pwm_out[2]) @(negedge clk);
        wr(2, O_RUN, 0);
        chk("R6 immediate low", 32'(pwm_out[2]), 0);
        rd(2, O_RUN, d); chk("R6 run reads 0", d, 0);
        wr(2, O_DIV, 1); wr(2, O_PER, 5); wr(2, O_HIGH, 2);
        wr(2, O_RUN, 1);
        chk("R7 low first cycle", 32'(pwm_out[2]), 0);
        @(negedge clk);
        chk("R7 high at restart", 32'(pwm_out[2]), 1);
        measure(2, 5, h, r);
        chk("R7 new high length", h + 1, 4);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(0, 5'h0C, 32'hFFFF);  rd(0, 5'h0C, d); chk("R8 hole reads 0", d, 0);
        wr(0, 5'h1C, 32'h1);     rd(0, 5'h1C, d); chk("R8 hole 0x1C reads 0", d, 0);
        wr(0, 5'h05, 32'h33);    rd(0, O_PER, d); chk("R8 misaligned write ignored", d, 5);
        rd(0, 5'h05, d);         chk("R8 misaligned read 0", d, 0);
        rd(0, O_RUN, d);         chk("R8 run untouched", d, 1);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_period();
        t_edges();
        t_shadow();
        t_stop_restart();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule